// File: doc/BRIEF.md
# Five-Level Alternating-Phase Carrier Modulator

This block drives the switches of a single-phase inverter made of two H-bridge cells in series: one fed from a full DC source, the other from half of it. It builds a sampled sinusoidal reference and four triangular carriers internally. The carriers share one frequency and amplitude, and each sits in its own quarter of the span from -1 to +1. Every carrier runs in phase opposition to its neighbours. Each clock, the reference is compared with all four carriers. The number of carriers it exceeds sets the output step, from minus full DC up to plus full DC in half-DC steps. That step is then turned into the gate pattern of both cells.

Three settings control the waveform. The first is the carrier half-period, given as a power of two in clocks. The second is the ratio of carrier frequency to reference frequency, normally 6. The third is the amplitude index, which reaches unity at 256. Values are fixed point, with 1.0 equal to 1024. All outputs are registered. Dead time and the analog power stage are handled elsewhere.

Top module: `apod_pwm5`

## Requirements
- R1: While rst_n is low, cmp_o is 4'b0011, lvl_o is 2, and both gate outputs hold the zero-state pattern 4'b1010.
- R2: The shape value L is hp_log2, forced into 1..9 (0 reads as 1, anything above 9 reads as 9), and the carrier half-period is 2^L clocks. A counter c runs 0..2^(L+1)-1 and wraps to 0. The triangle t is c while c < 2^L, and 2^(L+1)-c after that. Then u = t·2^(9-L), which covers 0..512. Carrier k (k = 0..3, where 0 is the lowest band) equals -1024 + 512k + u for even k and -1024 + 512k + 512 - u for odd k.
- R3: The ratio Q is freq_ratio, with 0 read as 1. A phase counter p runs 0..T-1 and wraps, where T = Q·2^(L+1), so one reference period lasts Q carrier periods. The angle is a = floor(p·65536/T) and h = a mod 32768. The magnitude is s = floor(4·h·(32768-h)/2^20), then m = floor(s·A/256), where A is amp capped at 256. The reference is -m when bit 15 of a is set, and +m otherwise.
- R4: Bit k of cmp_o is set when the reference exceeds carrier k. A reference equal to carrier k also sets the bit for the two lower bands (k = 0, 1) but not for the two upper bands. The outputs after the n-th rising edge since reset release reflect c = p = n-1, counted modulo their periods.
- R5: cmp_o is always thermometer-filled from bit 0: if a bit is set, every bit below it is set too.
- R6: lvl_o is the number of set bits in cmp_o (0..4). The output step in half-DC units is lvl_o - 2.
- R7: Each gate nibble is {right low, right high, left low, left high}. It reads 4'b1001 for a positive cell, 4'b0110 for a negative cell and 4'b1010 for zero. The cell states by lvl_o are: 4 gives full cell +, half cell 0; 3 gives full cell 0, half cell +; 2 gives both 0; 1 gives full cell 0, half cell -; 0 gives full cell -, half cell 0.
- R8: Within every leg of both cells, the high switch and the low switch are never on together or off together.
- R9: With amp at 0, lvl_o is 2 on every cycle.
- R10: With amp at 256, the step reaches both level code 0 and level code 4 within one reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hp_log2 | input | 4 | log2 of the carrier half-period in clocks |
| freq_ratio | input | 5 | Carrier periods per reference period |
| amp | input | 9 | Amplitude index, 256 = unity |
| cmp_o | output | 4 | Comparator result per carrier band, bit 0 lowest |
| lvl_o | output | 3 | Count of carriers exceeded (0..4) |
| gate_full_o | output | 4 | Gate pattern of the full-voltage cell |
| gate_half_o | output | 4 | Gate pattern of the half-voltage cell |

## Verification
Carrier or phase counters that are off by even one count move the comparator crossings. The cycle-exact comparison of cmp_o catches this at the first crossing that lands on a different edge, which is never more than one carrier period away. A wrong tie rule or a swapped band inversion either breaks the thermometer shape or leaves a non-zero step at zero amplitude, and either one appears on the next registered output. A mapping fault appears as a gate nibble that disagrees with lvl_o, or as a leg with both switches in the same state, in the very cycle the level code takes the affected value.

// File: rtl/apod_pkg.sv
package apod_pkg;

    localparam int NCAR = 4;

    typedef enum logic [1:0] {
        CELL_ZERO = 2'd0,
        CELL_POS  = 2'd1,
        CELL_NEG  = 2'd2
    } cell_e;

    // nibble = {right low, right high, left low, left high}
    function automatic logic [3:0] cell_gates(cell_e st);
        case (st)
            CELL_POS: return 4'b1001;
            CELL_NEG: return 4'b0110;
            default:  return 4'b1010;
        endcase
    endfunction

    function automatic int gate_weight(logic [3:0] g);
        if (g == 4'b1001) return 1;
        if (g == 4'b0110) return -1;
        return 0;
    endfunction

endpackage

// File: rtl/apod_carrier_gen.sv
module apod_carrier_gen #(
    parameter int FRAC = 10,
    parameter int LW   = 4,
    localparam int VW  = FRAC + 2,
    localparam int CW  = FRAC + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LW-1:0]        hp_log2,
    output logic signed [VW-1:0] car_o [apod_pkg::NCAR]
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] span_v, half_v, tri_v, rise_v;

    always_comb begin
        span_v   = CW'(2) << hp_log2;
        half_v   = span_v >> 1;
        st_d.cnt = (st_q.cnt >= span_v - 1'b1) ? '0 : st_q.cnt + 1'b1;
        tri_v    = (st_q.cnt < half_v) ? st_q.cnt : span_v - st_q.cnt;
        rise_v   = tri_v << (LW'(FRAC - 1) - hp_log2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < apod_pkg::NCAR; k++) begin : g_car
        localparam int BASE = -(2 ** FRAC) + k * (2 ** (FRAC - 1));
        if (k % 2 == 1) begin : g_inv
            assign car_o[k] = VW'(BASE + (2 ** (FRAC - 1)) - int'(rise_v));
        end else begin : g_dir
            assign car_o[k] = VW'(BASE + int'(rise_v));
        end
    end

    // R2: counter returns to zero right after its last count
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= span_v - 1'b1) |=> (st_q.cnt == '0));

endmodule

// File: rtl/apod_sine_ref.sv
module apod_sine_ref #(
    parameter int FRAC = 10,
    parameter int LW   = 4,
    parameter int RW   = 5,
    parameter int AMPW = 9,
    parameter int AW   = 16,
    localparam int VW  = FRAC + 2,
    localparam int PHW = RW + FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LW-1:0]        hp_log2,
    input  logic [RW-1:0]        ratio,
    input  logic [AMPW-1:0]      amp,
    output logic signed [VW-1:0] ref_o
);
    localparam int NW = PHW + AW;
    localparam int PW = 2 * AW + 2;
    localparam int SH = 2 * AW - 2 - FRAC;
    localparam int MW = FRAC + AMPW + 1;

    typedef struct packed {
        logic [PHW-1:0] ph;
    } st_t;

    st_t            st_d, st_q;
    logic [PHW-1:0] period_v;
    logic [AW-1:0]  angle_v, half_a, half_c;
    logic [PW-1:0]  prod_v;
    logic [FRAC:0]  mag_s, mag_a;
    logic [MW-1:0]  scaled_v;

    always_comb begin
        period_v = PHW'(ratio) << (hp_log2 + 1'b1);
        st_d.ph  = (st_q.ph >= period_v - 1'b1) ? '0 : st_q.ph + 1'b1;
        angle_v  = AW'({st_q.ph, {AW{1'b0}}} / NW'(period_v));
        half_a   = {1'b0, angle_v[AW-2:0]};
        half_c   = AW'(2 ** (AW - 1)) - half_a;
        prod_v   = (PW'(half_a) * PW'(half_c)) << 2;
        mag_s    = (FRAC + 1)'(prod_v >> SH);
        scaled_v = MW'(mag_s) * MW'(amp);
        mag_a    = (FRAC + 1)'(scaled_v >> (AMPW - 1));
        ref_o    = angle_v[AW-1] ? -VW'(mag_a) : VW'(mag_a);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: phase restarts after the last count of a reference period
    p_ph_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph >= period_v - 1'b1) |=> (st_q.ph == '0));

endmodule

// File: rtl/apod_level_map.sv
module apod_level_map (
    input  logic [apod_pkg::NCAR-1:0] cmp_i,
    output logic [2:0]                lvl_o,
    output logic [3:0]                gate_full_o,
    output logic [3:0]                gate_half_o
);
    import apod_pkg::*;

    cell_e full_st, half_st;

    always_comb begin
        lvl_o = '0;
        for (int k = 0; k < NCAR; k++) lvl_o = lvl_o + 3'(cmp_i[k]);
        full_st = CELL_ZERO;
        half_st = CELL_ZERO;
        case (lvl_o)
            3'd4: full_st = CELL_POS;
            3'd3: half_st = CELL_POS;
            3'd1: half_st = CELL_NEG;
            3'd0: full_st = CELL_NEG;
            default: ;
        endcase
        gate_full_o = cell_gates(full_st);
        gate_half_o = cell_gates(half_st);
    end

endmodule

// File: rtl/apod_pwm5.sv
module apod_pwm5 #(
    parameter int FRAC = 10,
    parameter int LW   = 4,
    parameter int RW   = 5,
    parameter int AMPW = 9,
    parameter int AW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   hp_log2,
    input  logic [RW-1:0]   freq_ratio,
    input  logic [AMPW-1:0] amp,
    output logic [3:0]      cmp_o,
    output logic [2:0]      lvl_o,
    output logic [3:0]      gate_full_o,
    output logic [3:0]      gate_half_o
);
    import apod_pkg::*;

    localparam int VW = FRAC + 2;
    localparam logic [LW-1:0]   L_MAX   = LW'(FRAC - 1);
    localparam logic [AMPW-1:0] AMP_ONE = AMPW'(2 ** (AMPW - 1));

    typedef struct packed {
        logic [3:0] cmp;
        logic [2:0] lvl;
        logic [3:0] gf;
        logic [3:0] gh;
    } out_t;

    localparam out_t OUT_RST = '{cmp: 4'b0011, lvl: 3'd2, gf: 4'b1010, gh: 4'b1010};

    logic [LW-1:0]        l_eff;
    logic [RW-1:0]        r_eff;
    logic [AMPW-1:0]      a_eff;
    logic signed [VW-1:0] car_v [NCAR];
    logic signed [VW-1:0] ref_v;
    logic [NCAR-1:0]      cmp_raw;
    logic [2:0]           lvl_v;
    logic [3:0]           gf_v, gh_v;
    out_t                 o_d, o_q;

    always_comb begin
        if (hp_log2 == '0)        l_eff = LW'(1);
        else if (hp_log2 > L_MAX) l_eff = L_MAX;
        else                      l_eff = hp_log2;
        r_eff = (freq_ratio == '0) ? RW'(1) : freq_ratio;
        a_eff = (amp > AMP_ONE) ? AMP_ONE : amp;
    end

    apod_carrier_gen #(.FRAC(FRAC), .LW(LW)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .hp_log2(l_eff),
        .car_o  (car_v)
    );

    apod_sine_ref #(.FRAC(FRAC), .LW(LW), .RW(RW), .AMPW(AMPW), .AW(AW)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .hp_log2(l_eff),
        .ratio  (r_eff),
        .amp    (a_eff),
        .ref_o  (ref_v)
    );

    for (genvar k = 0; k < NCAR; k++) begin : g_cmp
        if (k < NCAR / 2) begin : g_lo
            assign cmp_raw[k] = (ref_v >= car_v[k]);
        end else begin : g_hi
            assign cmp_raw[k] = (ref_v > car_v[k]);
        end
    end

    apod_level_map u_map (
        .cmp_i      (cmp_raw),
        .lvl_o      (lvl_v),
        .gate_full_o(gf_v),
        .gate_half_o(gh_v)
    );

    always_comb begin
        o_d = '{cmp: cmp_raw, lvl: lvl_v, gf: gf_v, gh: gh_v};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= OUT_RST;
        else        o_q <= o_d;
    end

    assign cmp_o       = o_q.cmp;
    assign lvl_o       = o_q.lvl;
    assign gate_full_o = o_q.gf;
    assign gate_half_o = o_q.gh;

    // R5: comparator bits fill upward from the lowest band
    p_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_o & (cmp_o + 4'd1)) == 4'd0);

    // R6: level code counts the comparator bits
    p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl_o) == $countones(cmp_o));

    // R7: the two cell contributions add up to the step
    p_cell_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (2 * gate_weight(gate_full_o) + gate_weight(gate_half_o)) == int'(lvl_o) - 2);

    // R8: each leg has exactly one switch on
    p_leg_comp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_full_o[0] != gate_full_o[1]) && (gate_full_o[2] != gate_full_o[3]) &&
        (gate_half_o[0] != gate_half_o[1]) && (gate_half_o[2] != gate_half_o[3]));

    // R9: zero amplitude gives the zero step on the next output
    p_zero_amp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (amp == '0) |=> (lvl_o == 3'd2));

endmodule

// File: tb/sim_apod_pwm5.sv
module sim_apod_pwm5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hp = 4'd6;
    logic [4:0] ratio = 5'd6;
    logic [8:0] amp = 9'd256;
    logic [3:0] cmp, gf, gh;
    logic [2:0] lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    apod_pwm5 u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .hp_log2    (hp),
        .freq_ratio (ratio),
        .amp        (amp),
        .cmp_o      (cmp),
        .lvl_o      (lvl),
        .gate_full_o(gf),
        .gate_half_o(gh)
    );

    // columns: hp_log2, ratio, amp, cycles, kind (1 = full swing, 2 = zero amplitude)
    localparam int NV = 9;
    localparam int VEC [NV][5] = '{
        '{6, 6, 256, 800, 1},
        '{5, 6, 200, 400, 0},
        '{3, 3, 128, 200, 0},
        '{1, 2, 256, 100, 0},
        '{9, 1, 256, 1100, 0},
        '{4, 0, 256, 100, 0},
        '{0, 4, 300, 100, 0},
        '{12, 2, 64, 2100, 0},
        '{6, 6, 0, 800, 2}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_cmp(input int l_in, input int r_in, input int a_in, input int idx);
        int le, re, ae, h, c, t, u, tr, ph, a, hf, s, m, rf, car;
        logic [3:0] b;
        le = (l_in < 1) ? 1 : ((l_in > 9) ? 9 : l_in);
        re = (r_in == 0) ? 1 : r_in;
        ae = (a_in > 256) ? 256 : a_in;
        h  = 1 << le;
        c  = idx % (2 * h);
        t  = (c < h) ? c : 2 * h - c;
        u  = t << (9 - le);
        tr = re * 2 * h;
        ph = idx % tr;
        a  = int'((longint'(ph) * 65536) / tr);
        hf = a % 32768;
        s  = int'((longint'(4) * hf * (32768 - hf)) >>> 20);
        m  = (s * ae) >>> 8;
        rf = (a >= 32768) ? -m : m;
        for (int k = 0; k < 4; k++) begin
            car = -1024 + 512 * k + (((k % 2) == 1) ? (512 - u) : u);
            b[k] = (k < 2) ? (rf >= car) : (rf > car);
        end
        return b;
    endfunction

    function automatic logic [7:0] model_gates(input int code);
        case (code)
            4: return {4'b1001, 4'b1010};
            3: return {4'b1010, 4'b1001};
            1: return {4'b1010, 4'b0110};
            0: return {4'b0110, 4'b1010};
            default: return {4'b1010, 4'b1010};
        endcase
    endfunction

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endfunction

    initial begin
        for (int v = 0; v < NV; v++) begin
            bit seen0, seen4;
            @(negedge clk);
            rst_n = 1'b0;
            hp    = 4'(VEC[v][0]);
            ratio = 5'(VEC[v][1]);
            amp   = 9'(VEC[v][2]);
            @(posedge clk);
            @(negedge clk);
            // R1: reset state, also reached in the middle of a running pattern
            chk(cmp == 4'b0011, "R1 cmp_o in reset", int'(cmp), 3);
            chk(lvl == 3'd2, "R1 lvl_o in reset", int'(lvl), 2);
            chk({gf, gh} == 8'b1010_1010, "R1 gates in reset", int'({gf, gh}), 8'hAA);
            rst_n = 1'b1;
            seen0 = 1'b0;
            seen4 = 1'b0;
            for (int n = 1; n <= VEC[v][3]; n++) begin
                logic [3:0] ec;
                int         el;
                logic [7:0] eg;
                @(posedge clk);
                @(negedge clk);
                ec = model_cmp(VEC[v][0], VEC[v][1], VEC[v][2], n - 1);
                el = $countones(ec);
                eg = model_gates(el);
                // R2 R3 R4: carriers, reference and compare rule, one cycle behind
                chk(cmp == ec, "R2/R3/R4 cmp_o", int'(cmp), int'(ec));
                // R5: thermometer shape
                chk((cmp & (cmp + 4'd1)) == 4'd0, "R5 cmp_o shape", int'(cmp), int'(ec));
                // R6: level code
                chk(int'(lvl) == el, "R6 lvl_o", int'(lvl), el);
                // R7: gate map
                chk({gf, gh} == eg, "R7 gates", int'({gf, gh}), int'(eg));
                // R8: legs complementary
                chk((gf[0] != gf[1]) && (gf[2] != gf[3]) && (gh[0] != gh[1]) && (gh[2] != gh[3]),
                    "R8 leg pairs", int'({gf, gh}), int'(eg));
                if (VEC[v][4] == 2) chk(lvl == 3'd2, "R9 zero amplitude", int'(lvl), 2);
                if (lvl == 3'd0) seen0 = 1'b1;
                if (lvl == 3'd4) seen4 = 1'b1;
            end
            if (VEC[v][4] == 1) begin
                chk(seen0, "R10 bottom level reached", int'(seen0), 1);
                chk(seen4, "R10 top level reached", int'(seen4), 1);
            end
        end
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule